// File: doc/BRIEF.md
# Address Break Comparator Channel

This block is one channel of a debug break unit. It monitors a processor bus and compares the address of each valid access with a programmed break address. A coded field selects how many of the low address bits are left out of the comparison. The channel also checks the kind of access (instruction fetch, data read or data write) and the bus master that issued it. When an access satisfies the address, kind and master conditions, a sticky match flag sets. If the interrupt enable is set, the flag drives a break interrupt request as a level.

Software reaches the channel through a small register port with two registers. Select 0 holds the break address, which is `ADDR_W` bits wide. Select 1 holds the control byte in the low 8 bits. Read data is combinational on `reg_sel`. Only a read that is strobed with `reg_rd_en` counts as a read of the flag. The flag clears only through a two-step handshake: software reads it as 1, then writes 0 to it.

Top module: `brk_chan`

## Requirements
- R1: After reset, the address register and the control byte read as 0, and `brk_irq` is 0.
- R2: A write with `reg_sel`=0 stores `reg_wdata` as the break address. A write with `reg_sel`=1 stores control bits 6..0 exactly as written. Writing 1 to control bit 7 (the match flag) never sets it.
- R3: Control bits 5..3 hold the mask code, which sets how many low address bits are ignored in the comparison: 0→0, 1→1, 2→2, 3→3, 4→4, 5→8, 6→12, 7→16. An address that differs only in ignored bits matches. An address that differs in the lowest compared bit does not match.
- R4: Control bits 2..1 select the access kind that qualifies: 00 fetch, 01 read, 10 write, 11 read or write. `bus_kind` encodes 00 fetch, 01 read, 10 write and 11 idle, and idle never matches.
- R5: Control bit 6 selects the bus master. When it is 0, only CPU accesses (`bus_xfer_ctl`=0) qualify. When it is 1, accesses from both the CPU and the transfer controller qualify.
- R6: A qualifying access presented with `bus_valid`=1 at a clock edge sets the flag (control bit 7), and the flag is visible right after that edge. The same access with `bus_valid`=0 has no effect.
- R7: Once set, the flag stays set. It clears only when control is written with bit 7 = 0 after a strobed read of control returned the flag as 1. A write of 0 without such a read leaves the flag at 1.
- R8: Any write to control disarms the read tracking. After read→write(bit 7 = 1)→write(bit 7 = 0), the flag stays 1.
- R9: If a qualifying access and a clearing write occur at the same edge, the flag stays 1.
- R10: `brk_irq` equals the flag ANDed with control bit 0 (interrupt enable). It drops in the cycle the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (arms flag clearing) |
| reg_sel | input | 1 | 0: break address, 1: control byte |
| reg_wdata | input | ADDR_W | Write data |
| reg_rdata | output | ADDR_W | Read data for the selected register |
| bus_valid | input | 1 | Bus access strobe |
| bus_addr | input | ADDR_W | Access address |
| bus_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 idle |
| bus_xfer_ctl | input | 1 | 1 when the transfer controller owns the access |
| brk_irq | output | 1 | Break interrupt request level |

## Verification
Every register effect lands at the first clock edge after the stimulus is applied. This covers address and control writes, flag set, arming and clearing. The bench therefore drives at the falling edge, lets one rising edge pass, and samples at the next falling edge. `brk_irq` is a combinational function of registered state, so it is checked in that same sampling slot. The scoreboard observes each result through `reg_rdata` with `reg_sel`=1 and `reg_rd_en` held low, so a check never arms the clearing handshake itself.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_IDLE  = 2'b11
    } bus_kind_e;

    // control byte, bit 7 down to bit 0
    typedef struct packed {
        logic       flag;
        logic       any_master;
        logic [2:0] mask_code;
        logic [1:0] cond;
        logic       irq_en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/brk_mask_gen.sv
module brk_mask_gen #(
    parameter int ADDR_W = 24
) (
    input  logic [2:0]        code,
    output logic [ADDR_W-1:0] care
);
    logic [4:0] ign_cnt;

    always_comb begin
        unique case (code)
            3'd5:    ign_cnt = 5'd8;
            3'd6:    ign_cnt = 5'd12;
            3'd7:    ign_cnt = 5'd16;
            default: ign_cnt = {2'b00, code};
        endcase
    end

    for (genvar i = 0; i < ADDR_W; i++) begin : g_care
        assign care[i] = (i >= int'(ign_cnt));
    end
endmodule

// File: rtl/brk_qual.sv
module brk_qual
    import brk_pkg::*;
(
    input  logic [1:0] cond,
    input  logic       any_master,
    input  logic [1:0] kind,
    input  logic       xfer_ctl,
    output logic       ok
);
    logic kind_ok;

    always_comb begin
        unique case (cond)
            2'b00:   kind_ok = (kind == KIND_FETCH);
            2'b01:   kind_ok = (kind == KIND_READ);
            2'b10:   kind_ok = (kind == KIND_WRITE);
            default: kind_ok = (kind == KIND_READ) || (kind == KIND_WRITE);
        endcase
    end

    assign ok = kind_ok && (any_master || !xfer_ctl);
endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp #(
    parameter int ADDR_W = 24
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic [ADDR_W-1:0] care,
    input  logic              qual_ok,
    output logic              hit
);
    assign hit = valid && qual_ok && (((addr ^ brk_addr) & care) == '0);
endmodule

// File: rtl/brk_ctrl_regs.sv
module brk_ctrl_regs
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              sel,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              hit,
    output logic [ADDR_W-1:0] brk_addr,
    output ctrl_t             ctrl,
    output logic              armed
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        ctrl_t             ctrl;
        logic              armed;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !sel) begin
            st_d.addr = wdata;
        end
        if (wr_en && sel) begin
            st_d.ctrl  = ctrl_t'({st_q.ctrl.flag, wdata[CTRL_W-2:0]});
            st_d.armed = 1'b0;
            if (!wdata[CTRL_W-1] && st_q.armed) begin
                st_d.ctrl.flag = 1'b0;
            end
        end else if (rd_en && sel && st_q.ctrl.flag) begin
            st_d.armed = 1'b1;
        end
        if (hit) begin
            st_d.ctrl.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign brk_addr = st_q.addr;
    assign ctrl     = st_q.ctrl;
    assign armed    = st_q.armed;
endmodule

// File: rtl/brk_chan.sv
module brk_chan
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_kind,
    input  logic              bus_xfer_ctl,
    output logic              brk_irq
);
    localparam int PAD_W = ADDR_W - CTRL_W;

    logic [ADDR_W-1:0] brk_addr_w;
    logic [ADDR_W-1:0] care_w;
    ctrl_t             ctrl_w;
    logic              armed_w;
    logic              qual_w;
    logic              hit_w;

    brk_mask_gen #(.ADDR_W(ADDR_W)) u_mask (
        .code (ctrl_w.mask_code),
        .care (care_w)
    );

    brk_qual u_qual (
        .cond       (ctrl_w.cond),
        .any_master (ctrl_w.any_master),
        .kind       (bus_kind),
        .xfer_ctl   (bus_xfer_ctl),
        .ok         (qual_w)
    );

    brk_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .valid    (bus_valid),
        .addr     (bus_addr),
        .brk_addr (brk_addr_w),
        .care     (care_w),
        .qual_ok  (qual_w),
        .hit      (hit_w)
    );

    brk_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .hit      (hit_w),
        .brk_addr (brk_addr_w),
        .ctrl     (ctrl_w),
        .armed    (armed_w)
    );

    assign reg_rdata = reg_sel ? {{PAD_W{1'b0}}, ctrl_w} : brk_addr_w;
    assign brk_irq   = ctrl_w.flag && ctrl_w.irq_en;
endmodule

// File: rtl/brk_chan_chk.sv
module brk_chan_chk (
    input logic clk,
    input logic rst_n,
    input logic reg_wr_en,
    input logic reg_sel,
    input logic wbit7,
    input logic bus_valid,
    input logic [1:0] bus_kind,
    input logic hit,
    input logic flag,
    input logic armed,
    input logic irq
);
    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R6
    AST_NO_HIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid || bus_kind == 2'b11) |-> !hit); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(reg_wr_en && reg_sel && !wbit7 && armed)) |=> flag); // R7
    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(armed && reg_wr_en && reg_sel)); // R7
    AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_sel) |=> !armed); // R8
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !irq); // R10
endmodule

bind brk_chan brk_chan_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_sel   (reg_sel),
    .wbit7     (reg_wdata[7]),
    .bus_valid (bus_valid),
    .bus_kind  (bus_kind),
    .hit       (hit_w),
    .flag      (ctrl_w.flag),
    .armed     (armed_w),
    .irq       (brk_irq)
);

// File: tb/sim_brk_chan.sv
module sim_brk_chan;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic          reg_rd_en = 1'b0;
    logic          reg_sel = 1'b0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_kind = 2'b11;
    logic          bus_xfer_ctl = 1'b0;
    logic          brk_irq;

    always #5 clk = ~clk;

    brk_chan #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_kind(bus_kind),
        .bus_xfer_ctl(bus_xfer_ctl), .brk_irq(brk_irq)
    );

    typedef struct {
        string         req;
        logic          sel;
        bit            is_irq;
        logic [AW-1:0] mask;
        logic [AW-1:0] exp;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;
    int    vectors = 0;
    int    miscompares = 0;
    logic [7:0] cur_ctrl = 8'h00;
    bit    done = 1'b0;

    // monitor: pops expected items and compares with the live outputs
    initial begin
        forever begin
            @(sample_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [AW-1:0] act;
                it = sb_q.pop_front();
                act = it.is_irq ? {{(AW-1){1'b0}}, brk_irq} : (reg_rdata & it.mask);
                vectors++;
                if (act !== it.exp) begin
                    miscompares++;
                    $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_reg(string req, logic sel, logic [AW-1:0] mask, logic [AW-1:0] exp);
        item_t it;
        reg_sel = sel;
        it.req = req; it.sel = sel; it.is_irq = 1'b0; it.mask = mask; it.exp = exp & mask;
        sb_q.push_back(it);
        ->sample_ev;
        #2;
    endtask

    task automatic expect_irq(string req, logic exp);
        item_t it;
        it.req = req; it.sel = 1'b1; it.is_irq = 1'b1; it.mask = '1;
        it.exp = {{(AW-1){1'b0}}, exp};
        sb_q.push_back(it);
        ->sample_ev;
        #2;
    endtask

    task automatic expect_flag(string req, logic exp);
        expect_reg(req, 1'b1, 24'h80, {16'h0, exp, 7'h0});
    endtask

    task automatic wr(logic sel, logic [AW-1:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
        if (sel) cur_ctrl = {1'b0, d[6:0]};
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_ctrl();
        reg_sel = 1'b1; reg_rd_en = 1'b1;
        tick();
        reg_rd_en = 1'b0;
    endtask

    task automatic access(logic [AW-1:0] a, logic [1:0] k, logic x, logic v);
        bus_valid = v; bus_addr = a; bus_kind = k; bus_xfer_ctl = x;
        tick();
        bus_valid = 1'b0; bus_kind = 2'b11;
    endtask

    task automatic clear_flag();
        rd_ctrl();
        wr(1'b1, {16'h0, 1'b0, cur_ctrl[6:0]});
    endtask

    task automatic probe(string req, logic [AW-1:0] a, logic [1:0] k, logic x, logic exp);
        clear_flag();
        access(a, k, x, 1'b1);
        expect_flag(req, exp);
    endtask

    function automatic int ign_bits(int code);
        case (code)
            5: return 8;
            6: return 12;
            7: return 16;
            default: return code;
        endcase
    endfunction

    localparam logic [AW-1:0] BA = 24'h5A5A5A;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        expect_reg("R1 ctrl", 1'b1, '1, '0);
        expect_reg("R1 addr", 1'b0, '1, '0);
        expect_irq("R1 irq", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 register storage
        wr(1'b0, 24'hABCDEF);
        expect_reg("R2 addr", 1'b0, '1, 24'hABCDEF);
        wr(1'b1, 24'h0000FF);
        expect_reg("R2 ctrl", 1'b1, '1, 24'h00007F);
        expect_irq("R10 no flag", 1'b0);

        // R3 mask codes, fetch condition, CPU master
        wr(1'b0, BA);
        for (int c = 0; c < 8; c++) begin
            int n;
            n = ign_bits(c);
            wr(1'b1, {16'h0, 2'b00, c[2:0], 2'b00, 1'b0});
            probe("R3 exact", BA, 2'b00, 1'b0, 1'b1);
            if (n > 0) probe("R3 masked bit", BA ^ (24'h1 << (n - 1)), 2'b00, 1'b0, 1'b1);
            probe("R3 compared bit", BA ^ (24'h1 << n), 2'b00, 1'b0, 1'b0);
        end

        // R4 condition select
        for (int cs = 0; cs < 4; cs++) begin
            wr(1'b1, {16'h0, 2'b00, 3'b000, cs[1:0], 1'b0});
            for (int k = 0; k < 4; k++) begin
                logic e;
                case (cs)
                    0: e = (k == 0);
                    1: e = (k == 1);
                    2: e = (k == 2);
                    default: e = (k == 1) || (k == 2);
                endcase
                probe("R4 kind", BA, k[1:0], 1'b0, e);
            end
        end

        // R5 master select
        wr(1'b1, {16'h0, 2'b00, 3'b000, 2'b11, 1'b0});
        probe("R5 cpu only, xfer", BA, 2'b10, 1'b1, 1'b0);
        probe("R5 cpu only, cpu", BA, 2'b10, 1'b0, 1'b1);
        wr(1'b1, {16'h0, 2'b01, 3'b000, 2'b11, 1'b0});
        probe("R5 any, xfer", BA, 2'b01, 1'b1, 1'b1);

        // R6 valid strobe required
        clear_flag();
        access(BA, 2'b01, 1'b0, 1'b0);
        expect_flag("R6 no valid", 1'b0);
        access(BA, 2'b01, 1'b0, 1'b1);
        expect_flag("R6 set", 1'b1);

        // R7 clear handshake
        wr(1'b1, {16'h0, 1'b0, cur_ctrl[6:0]});
        expect_flag("R7 write0 without read", 1'b1);
        rd_ctrl();
        wr(1'b1, {16'h0, 1'b0, cur_ctrl[6:0]});
        expect_flag("R7 read then write0", 1'b0);

        // R8 intervening write disarms
        access(BA, 2'b01, 1'b0, 1'b1);
        rd_ctrl();
        wr(1'b1, {16'h0, 1'b1, cur_ctrl[6:0]});
        wr(1'b1, {16'h0, 1'b0, cur_ctrl[6:0]});
        expect_flag("R8 disarmed", 1'b1);

        // R9 match with clearing write
        rd_ctrl();
        bus_valid = 1'b1; bus_addr = BA; bus_kind = 2'b01; bus_xfer_ctl = 1'b0;
        wr(1'b1, {16'h0, 1'b0, cur_ctrl[6:0]});
        bus_valid = 1'b0; bus_kind = 2'b11;
        expect_flag("R9 simultaneous", 1'b1);

        // R10 interrupt level
        expect_irq("R10 ie off", 1'b0);
        wr(1'b1, {16'h0, 1'b0, cur_ctrl[6:1], 1'b1});
        expect_irq("R10 ie on", 1'b1);
        clear_flag();
        expect_irq("R10 after clear", 1'b0);
        expect_flag("R10 flag cleared", 1'b0);

        @(negedge clk);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule